// File: doc/BRIEF.md
# I/Q Decimation Filter

This block takes paired in-phase and quadrature samples straight from the converter, at the full sample rate, and returns a slower stream of filtered pairs. Each branch is a cascaded integrator-comb filter. A 3-bit select word sets the decimation factor. The factor is a power of two from 1 (bypass) up to 16. Both branches run in lockstep from one shared counter, so every output strobe carries an aligned I/Q pair.

Each select value also fixes a gain. The raw filter growth of R^K (R is the factor, K is the stage count) is divided out. The result is then scaled up by the gain for that select value, and saturated to the output width. The converter clock can be picked so that the symbol rate gets as many samples per symbol as possible with the tightest filter that still fits. The block itself only applies whichever setting it is given.

Input and output are valid/ready streams. An input pair is taken on a cycle where `s_valid` and `s_ready` are both high. `s_ready` is low while the output register holds a pair that is not being drained that cycle. It is also low for one cycle after any change of the effective select value. An output pair stays on `m_i`/`m_q`, unchanged, from the cycle `m_valid` rises until the cycle in which `m_ready` is high.

Top module: `iq_decimator`

## Requirements
- R1: The I and Q branches filter their own inputs with identical settings, and each output strobe delivers both results of the same input window together.
- R2: The select values 0, 1, 2, 3 and 4 give factors 1, 2, 4, 8 and 16. The values 5, 6 and 7 act exactly as 4, and switching among values that map to the same factor causes no clear.
- R3: With factor 1, every accepted pair appears unchanged on the output in the next cycle, with `m_valid` high.
- R4: With factor R > 1, one output pair is produced for every R accepted input pairs, counted from the last clear. It appears in the cycle after the R-th of those inputs is accepted.
- R5: An output value equals floor(G * S / R^K), where K = 2 stages and S is the K-times-repeated R-sample running sum of the accepted inputs since the last clear (earlier inputs count as zero). G is 1 for select 0 and 1, and 2^(select-1) for select 2 to 4.
- R6: Results beyond the signed output range are clamped to its largest or smallest value.
- R7: A change of the effective select value drops `s_ready` for one cycle. During that cycle the filter history and the input counter are cleared, and the new factor is in force from the next cycle. An output pair already waiting is kept.
- R8: While `m_valid` is high and `m_ready` is low, `s_ready` is low and the output pair does not change.
- R9: During and right after reset, `m_valid` is low, factor 1 is active and the filter history is zero.
- R10: Long runs of full-scale inputs at factor 16 give exact results; wrap-around in the integrators does not affect any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sel | input | 3 | Decimation select value |
| s_valid | input | 1 | Input pair valid |
| s_ready | output | 1 | Block accepts an input pair this cycle |
| s_i | input | IN_W | In-phase input sample, signed |
| s_q | input | IN_W | Quadrature input sample, signed |
| m_valid | output | 1 | Output pair valid |
| m_ready | input | 1 | Downstream takes the output pair |
| m_i | output | OUT_W | In-phase output, signed |
| m_q | output | OUT_W | Quadrature output, signed |

## Verification
The bench builds the block with 12-bit inputs and outputs and two filter stages. At factor 16 this gives a 20-bit accumulator, so a few hundred full-scale samples are enough to make the integrators wrap many times. A steady full-scale input times the gain of 8 is far outside 12 bits, so the clamp is hit at both ends. The equal input and output widths also let bypass be compared sample for sample.

// File: rtl/iqd_pkg.sv
package iqd_pkg;
  localparam int SEL_W   = 3;
  localparam int SEL_MAX = 4;   // log2 of the largest factor

  // values above the largest code behave as the largest code
  function automatic logic [SEL_W-1:0] sel_clamp(input logic [SEL_W-1:0] s);
    return (s > SEL_W'(SEL_MAX)) ? SEL_W'(SEL_MAX) : s;
  endfunction

  // log2 of the level gain tied to each select value
  function automatic int gain_log2(input logic [SEL_W-1:0] s);
    return (s <= SEL_W'(1)) ? 0 : int'(s) - 1;
  endfunction

  // right shift that removes R^K growth and applies the gain
  function automatic int net_shift(input logic [SEL_W-1:0] s, input int stages);
    return stages * int'(s) - gain_log2(s);
  endfunction
endpackage

// File: rtl/iqd_ctrl.sv
module iqd_ctrl
  import iqd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic             s_valid,
  input  logic             out_busy,
  output logic             s_ready,
  output logic             clr,
  output logic             accept,
  output logic             fire,
  output logic [SEL_W-1:0] act_sel
);
  localparam int CNT_W = (SEL_MAX > 0) ? SEL_MAX : 1;

  logic [SEL_W-1:0] act_q;
  logic [SEL_W-1:0] want;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             last;

  assign want    = sel_clamp(cfg_sel);
  assign clr     = (want != act_q);
  assign s_ready = !clr && !out_busy;
  assign accept  = s_valid && s_ready;
  assign lim     = CNT_W'((32'd1 << act_q) - 32'd1);
  assign last    = (cnt_q == lim);
  assign fire    = accept && last;
  assign act_sel = act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      act_q <= want;
      cnt_q <= '0;
    end else if (accept) begin
      cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/iqd_cic.sv
module iqd_cic #(
  parameter int IN_W   = 12,
  parameter int STAGES = 2,
  parameter int GUARD  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 accept,
  input  logic                 fire,
  input  logic [IN_W-1:0]      din,
  output logic [IN_W+GUARD-1:0] dout
);
  localparam int ACC_W = IN_W + GUARD;

  logic [ACC_W-1:0] isum [STAGES+1];
  logic [ACC_W-1:0] cval [STAGES+1];

  assign isum[0] = {{GUARD{din[IN_W-1]}}, din};
  assign cval[0] = isum[STAGES];
  assign dout    = cval[STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stg
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] dly_q;

    // integrator runs at input rate, comb differentiates at output rate
    assign isum[k+1] = acc_q + isum[k];
    assign cval[k+1] = cval[k] - dly_q;

    always_ff @(posedge clk) begin
      if (rst || clr) begin
        acc_q <= '0;
        dly_q <= '0;
      end else begin
        if (accept) acc_q <= isum[k+1];
        if (fire)   dly_q <= cval[k];
      end
    end
  end
endmodule

// File: rtl/iqd_scale.sv
module iqd_scale
  import iqd_pkg::*;
#(
  parameter int ACC_W  = 20,
  parameter int OUT_W  = 12,
  parameter int STAGES = 2
) (
  input  logic [SEL_W-1:0] act_sel,
  input  logic [ACC_W-1:0] din,
  output logic [OUT_W-1:0] dout
);
  localparam logic signed [ACC_W-1:0] HI = {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] LO = ~HI;

  logic signed [ACC_W-1:0] shifted;
  int sh;

  always_comb begin
    sh      = net_shift(act_sel, STAGES);
    shifted = $signed(din) >>> sh;
    if (shifted > HI)      dout = HI[OUT_W-1:0];
    else if (shifted < LO) dout = LO[OUT_W-1:0];
    else                   dout = shifted[OUT_W-1:0];
  end
endmodule

// File: rtl/iq_decimator.sv
module iq_decimator
  import iqd_pkg::*;
#(
  parameter int IN_W   = 12,
  parameter int OUT_W  = 12,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [IN_W-1:0]  s_i,
  input  logic [IN_W-1:0]  s_q,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [OUT_W-1:0] m_i,
  output logic [OUT_W-1:0] m_q
);
  localparam int GUARD = STAGES * SEL_MAX;
  localparam int ACC_W = IN_W + GUARD;
  localparam int NCH   = 2;

  logic             clr, accept, fire;
  logic [SEL_W-1:0] act_sel;
  logic [IN_W-1:0]  din    [NCH];
  logic [OUT_W-1:0] scaled [NCH];

  assign din[0] = s_i;
  assign din[1] = s_q;

  iqd_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cfg_sel  (cfg_sel),
    .s_valid  (s_valid),
    .out_busy (m_valid && !m_ready),
    .s_ready  (s_ready),
    .clr      (clr),
    .accept   (accept),
    .fire     (fire),
    .act_sel  (act_sel)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [ACC_W-1:0] comb_out;

    iqd_cic #(.IN_W(IN_W), .STAGES(STAGES), .GUARD(GUARD)) u_cic (
      .clk    (clk),
      .rst    (rst),
      .clr    (clr),
      .accept (accept),
      .fire   (fire),
      .din    (din[c]),
      .dout   (comb_out)
    );

    iqd_scale #(.ACC_W(ACC_W), .OUT_W(OUT_W), .STAGES(STAGES)) u_scale (
      .act_sel (act_sel),
      .din     (comb_out),
      .dout    (scaled[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_i     <= '0;
      m_q     <= '0;
    end else begin
      if (m_valid && m_ready) m_valid <= 1'b0;
      if (fire) begin
        m_valid <= 1'b1;
        m_i     <= scaled[0];
        m_q     <= scaled[1];
      end
    end
  end
endmodule

// File: rtl/iqd_checker.sv
module iqd_checker
  import iqd_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int OUT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic [SEL_W-1:0] cfg_sel,
  input logic             s_valid,
  input logic             s_ready,
  input logic [IN_W-1:0]  s_i,
  input logic [IN_W-1:0]  s_q,
  input logic             m_valid,
  input logic             m_ready,
  input logic [OUT_W-1:0] m_i,
  input logic [OUT_W-1:0] m_q
);
  logic seen;
  always_ff @(posedge clk) seen <= !rst;

  // R8: a stalled output pair stays put
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_i) && $stable(m_q)));

  // R8: no input is taken while the output is stalled
  a_r8_stall: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |-> !s_ready);

  // R3: bypass passes the accepted pair through in one cycle
  a_r3_bypass: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready && cfg_sel == '0) |=>
      (m_valid && $signed(m_i) == $signed($past(s_i)) && $signed(m_q) == $signed($past(s_q))));

  // R7: an effective select change blocks input for the clear cycle
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (seen && sel_clamp(cfg_sel) != sel_clamp($past(cfg_sel))) |-> !s_ready);

  // R9: reset empties the output
  a_r9_reset: assert property (@(posedge clk) rst |=> !m_valid);
endmodule

bind iq_decimator iqd_checker #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cfg_sel (cfg_sel),
  .s_valid (s_valid),
  .s_ready (s_ready),
  .s_i     (s_i),
  .s_q     (s_q),
  .m_valid (m_valid),
  .m_ready (m_ready),
  .m_i     (m_i),
  .m_q     (m_q)
);

// File: tb/iq_decimator_bench.sv
module iq_decimator_bench;
  localparam int IN_W  = 12;
  localparam int OUT_W = 12;
  localparam int STG   = 2;
  localparam longint HI = (longint'(1) << (OUT_W-1)) - 1;
  localparam longint LO = -(longint'(1) << (OUT_W-1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] cfg_sel = '0;
  logic s_valid = 1'b0, s_ready;
  logic [IN_W-1:0] s_i = '0, s_q = '0;
  logic m_valid, m_ready = 1'b0;
  logic [OUT_W-1:0] m_i, m_q;

  always #10 clk = ~clk;

  iq_decimator #(.IN_W(IN_W), .OUT_W(OUT_W), .STAGES(STG)) u_iq_decimator (
    .clk(clk), .rst(rst), .cfg_sel(cfg_sel),
    .s_valid(s_valid), .s_ready(s_ready), .s_i(s_i), .s_q(s_q),
    .m_valid(m_valid), .m_ready(m_ready), .m_i(m_i), .m_q(m_q)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  // behavioural reference state
  int act = 0, cnt = 0;
  longint hq[2][STG][$];
  bit e_mv = 1'b0;
  longint e_out[2];

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      report();
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint a, input longint e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, a, e);
    end
  endtask

  function automatic int clampsel(input int s);
    return (s > 4) ? 4 : s;
  endfunction

  function automatic longint sat(input longint v);
    if (v > HI) return HI;
    if (v < LO) return LO;
    return v;
  endfunction

  task automatic step(input bit v, input int xi, input int xq, input bit rdy,
                      input int sel, input string tag);
    int want;
    bit pend, er, fire;
    longint res[2];
    s_valid = v; s_i = IN_W'(xi); s_q = IN_W'(xq); m_ready = rdy; cfg_sel = 3'(sel);
    #1;
    want = clampsel(sel);
    pend = (want != act);
    er = !pend && (!e_mv || rdy);
    chk(s_ready == er, tag, "s_ready", longint'(s_ready), longint'(er));
    fire = 1'b0;
    if (pend) begin
      act = want; cnt = 0;
      for (int c = 0; c < 2; c++) for (int k = 0; k < STG; k++) hq[c][k].delete();
    end else if (v && er) begin
      int r = 1 << act;
      for (int c = 0; c < 2; c++) begin
        longint val = (c == 0) ? longint'(xi) : longint'(xq);
        for (int k = 0; k < STG; k++) begin
          longint s = 0;
          hq[c][k].push_back(val);
          if (hq[c][k].size() > r) void'(hq[c][k].pop_front());
          foreach (hq[c][k][j]) s += hq[c][k][j];
          val = s;
        end
        res[c] = val;
      end
      if (cnt == r - 1) begin fire = 1'b1; cnt = 0; end
      else cnt++;
    end
    if (e_mv && rdy) e_mv = 1'b0;
    if (fire) begin
      int g = (act <= 1) ? 0 : act - 1;
      e_mv = 1'b1;
      for (int c = 0; c < 2; c++) e_out[c] = sat((res[c] <<< g) >>> (STG * act));
    end
    @(posedge clk);
    @(negedge clk);
    chk(m_valid == e_mv, tag, "m_valid", longint'(m_valid), longint'(e_mv));
    if (e_mv) begin
      chk(longint'($signed(m_i)) == e_out[0], tag, "m_i", longint'($signed(m_i)), e_out[0]);
      chk(longint'($signed(m_q)) == e_out[1], tag, "m_q", longint'($signed(m_q)), e_out[1]);
    end
  endtask

  // mode 0 random, 1 full-scale positive, 2 full-scale negative
  task automatic phase(input int sel, input int n, input int vpct, input int rpct,
                       input int mode, input string tag);
    for (int t = 0; t < n; t++) begin
      int a, b;
      bit v = ($urandom_range(0, 99) < vpct);
      bit r = ($urandom_range(0, 99) < rpct);
      case (mode)
        1: begin a = 2047; b = 2047; end
        2: begin a = -2048; b = -2048; end
        default: begin
          a = int'($urandom_range(0, 4095)) - 2048;
          b = int'($urandom_range(0, 4095)) - 2048;
        end
      endcase
      step(v, a, b, r, sel, tag);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(m_valid == 1'b0, "R9", "m_valid in reset", longint'(m_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(m_valid == 1'b0, "R9", "m_valid after reset", longint'(m_valid), 0);
    // bypass, both branches, no stall
    phase(0, 60, 100, 100, 0, "R3 R1");
    phase(0, 80, 70, 50, 0, "R8 R3");
    // each factor, with gaps and stalls
    phase(1, 100, 80, 90, 0, "R4 R5 R7");
    phase(2, 120, 80, 90, 0, "R4 R5 R1");
    phase(3, 200, 90, 80, 0, "R4 R5");
    phase(4, 300, 90, 70, 0, "R5 R8");
    // clamp and wrap-around
    phase(4, 400, 100, 100, 1, "R6 R10");
    phase(4, 400, 100, 100, 2, "R6 R10");
    phase(4, 800, 95, 90, 0, "R10");
    // out-of-range codes map to the largest factor
    phase(5, 150, 90, 90, 0, "R2");
    phase(7, 150, 90, 90, 0, "R2");
    phase(6, 80, 90, 90, 2, "R2 R6");
    // select change with a waiting output and partial history
    phase(2, 7, 100, 0, 0, "R7");
    phase(3, 6, 100, 0, 0, "R7 R8");
    phase(3, 80, 90, 80, 0, "R7");
    phase(1, 3, 100, 100, 0, "R7");
    phase(2, 3, 100, 100, 0, "R7");
    phase(0, 40, 100, 100, 0, "R7 R3");
    // reset mid-run clears history and output
    phase(3, 11, 100, 0, 0, "R9");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(m_valid == 1'b0, "R9", "m_valid after mid reset", longint'(m_valid), 0);
    act = 0; cnt = 0; e_mv = 1'b0;
    for (int c = 0; c < 2; c++) for (int k = 0; k < STG; k++) hq[c][k].delete();
    phase(0, 30, 100, 100, 0, "R9 R3");
    phase(2, 60, 100, 100, 0, "R9 R4");
    report();
  end
endmodule